// File: doc/BRIEF.md
# Sub-Clock Sleep Sequencing Controller

This block follows the operating mode of a small microcontroller and runs the entry into, and exit from, a low-power sleep mode that runs on the sub-clock. A one-cycle sleep strobe from the CPU, qualified by three configuration bits, moves the chip from the high-speed active mode to sub-active mode. From sub-active mode, the same strobe moves it into sub-sleep. In sub-sleep the CPU clock is gated off. Every peripheral clock is also gated off, apart from a fixed set of always-on channels (by default two 8-bit timers and two watchdogs).

Wake-up sources are checked one by one. The NMI always wakes the chip. An external IRQ line wakes it only when that line's enable bit is set. A peripheral interrupt wakes it only when its enable is set and the CPU interrupt mask is clear. A wake-up returns the chip to sub-active mode and issues a one-cycle exception-start pulse with a cause code.

Two pins override everything else. A low standby pin forces hardware standby from any mode, and the chip leaves hardware standby only through reset. A low reset pin puts the chip in a reset-hold mode with all clocks running. Reset exception handling starts only when the pin is high and a programmable stabilization count has run out.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, `mode` reads 1 (reset-hold), `cpu_clk_en` is 1, `per_clk_en` is all ones, and `exc_start` and `exc_cause` are 0. Mode codes are: 0 hardware standby, 1 reset-hold, 2 active, 3 sub-active, 4 sub-sleep.
- R2: With `stby_n` high, a low `res_n` moves any mode to reset-hold at the next edge. On entry from any other mode, the stabilization counter loads `stab_cycles`.
- R3: Reset-hold is left for active mode at the first edge where `res_n` is high and the counter has reached zero. That edge comes no sooner than `stab_cycles`+1 edges after the entry edge. Leaving reset-hold issues `exc_start` with `exc_cause` = 1.
- R4: A low `stby_n` moves any mode to hardware standby (mode 0) at the next edge, even while `res_n` is low. In hardware standby all clock enables are 0. The mode is left only for reset-hold, when `res_n` is low and `stby_n` is high.
- R5: In active mode, a sleep strobe with {`cfg_ssby`,`cfg_lson`,`cfg_pss`} = 3'b011 moves to sub-active. In sub-active mode, a strobe with `cfg_ssby`=0 and `cfg_lson`=0 returns to active.
- R6: Sub-sleep is entered only from sub-active mode, and only by a sleep strobe with {`cfg_ssby`,`cfg_lson`,`cfg_pss`} = 3'b011. Any other strobe combination leaves the mode unchanged, apart from the return to active described in R5.
- R7: In sub-sleep, `cpu_clk_en` is 0 and `per_clk_en` equals `KEEP_MASK` (default 8'h0F). In reset-hold, active and sub-active modes, all enables are 1.
- R8: In sub-sleep, a high `nmi` moves to sub-active at the next edge and issues `exc_start` with cause 2. In other modes, interrupts produce no pulse and no mode change.
- R9: In sub-sleep, IRQ line k wakes the chip with cause 4+k only when both `irq_req[k]` and `irq_en[k]` are 1. A request on a disabled line leaves the mode, the clocks and `exc_start` unchanged.
- R10: In sub-sleep, any `pirq_req[p]` with `pirq_en[p]`=1 and `cpu_mask`=0 wakes the chip with cause 12. A disabled or masked request does not wake it.
- R11: Wake priority runs standby, then reset, then NMI, then IRQ lines from the lowest index upward, then peripherals. A reset during sub-sleep goes to reset-hold with no interrupt pulse.
- R12: `exc_start` is high for exactly one cycle, and `exc_cause` holds its value until the next pulse. While the chip stays in sub-sleep, `exc_cause` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle sleep request from the CPU |
| cfg_ssby | input | 1 | Standby-select configuration bit |
| cfg_lson | input | 1 | Low-speed-on configuration bit |
| cfg_pss | input | 1 | Watchdog prescaler-select configuration bit |
| irq_req | input | NIRQ | External IRQ line requests |
| irq_en | input | NIRQ | External IRQ line enables |
| nmi | input | 1 | Non-maskable interrupt request |
| pirq_req | input | NPI | Peripheral interrupt requests |
| pirq_en | input | NPI | Peripheral interrupt enables |
| cpu_mask | input | 1 | CPU mask blocking peripheral interrupts |
| res_n | input | 1 | Active-low reset pin, already synchronized |
| stby_n | input | 1 | Active-low standby pin, already synchronized |
| stab_cycles | input | CNT_W | Oscillator stabilization count |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | NPER | Per-peripheral clock enables |
| exc_start | output | 1 | One-cycle exception-start pulse |
| exc_cause | output | 4 | Cause code of the last exception start |
| mode | output | 3 | Current operating mode |

## Verification
Each output is a register loaded from the same next-state decision. Any mode change, clock-enable change or exception pulse therefore appears at the first rising edge after the input that caused it. The bench drives inputs on the falling edge and reads outputs on the following falling edge. The stabilization exit is measured by counting falling edges from the entry edge until active mode appears, and the count is compared with `stab_cycles`+1, or with 1 when the pin is released after the count has expired. Negative cases (disabled IRQ lines, masked peripherals) are held for several cycles, and every one of those cycles is checked before the source is enabled.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_HWSTBY = 3'd0,
    PM_RESET  = 3'd1,
    PM_ACTIVE = 3'd2,
    PM_SUBACT = 3'd3,
    PM_SUBSLP = 3'd4
  } pm_mode_e;

  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CZ_NONE     = 4'd0;
  localparam logic [CAUSE_W-1:0] CZ_RESET    = 4'd1;
  localparam logic [CAUSE_W-1:0] CZ_NMI      = 4'd2;
  localparam logic [CAUSE_W-1:0] CZ_IRQ_BASE = 4'd4;
  localparam logic [CAUSE_W-1:0] CZ_PERIPH   = 4'd12;
endpackage

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
  import pwr_mode_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NPI  = 4
) (
  input  logic               nmi,
  input  logic [NIRQ-1:0]    irq_req,
  input  logic [NIRQ-1:0]    irq_en,
  input  logic [NPI-1:0]     pirq_req,
  input  logic [NPI-1:0]     pirq_en,
  input  logic               cpu_mask,
  output logic               wake_vld,
  output logic [CAUSE_W-1:0] wake_cause
);
  logic [NIRQ-1:0] irq_live;
  logic            pirq_live;

  assign irq_live  = irq_req & irq_en;
  assign pirq_live = (|(pirq_req & pirq_en)) & ~cpu_mask;

  // Later assignments win: lowest priority is written first.
  always_comb begin
    wake_vld   = 1'b0;
    wake_cause = CZ_NONE;
    if (pirq_live) begin
      wake_vld   = 1'b1;
      wake_cause = CZ_PERIPH;
    end
    for (int k = NIRQ - 1; k >= 0; k--) begin
      if (irq_live[k]) begin
        wake_vld   = 1'b1;
        wake_cause = CZ_IRQ_BASE + CAUSE_W'(k);
      end
    end
    if (nmi) begin
      wake_vld   = 1'b1;
      wake_cause = CZ_NMI;
    end
  end
endmodule

// File: rtl/pwr_stab_cnt.sv
module pwr_stab_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0);
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_mode_pkg::*;
#(
  parameter int              NPER      = 8,
  parameter logic [NPER-1:0] KEEP_MASK = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  pm_mode_e        mode_nxt,
  output logic            cpu_en,
  output logic [NPER-1:0] per_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_en <= 1'b1;
      per_en <= '1;
    end else begin
      case (mode_nxt)
        PM_HWSTBY: begin
          cpu_en <= 1'b0;
          per_en <= '0;
        end
        PM_SUBSLP: begin
          cpu_en <= 1'b0;
          per_en <= KEEP_MASK;
        end
        default: begin
          cpu_en <= 1'b1;
          per_en <= '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int              NIRQ      = 8,
  parameter int              NPI       = 4,
  parameter int              NPER      = 8,
  parameter logic [NPER-1:0] KEEP_MASK = 8'h0F,
  parameter int              CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_stb,
  input  logic               cfg_ssby,
  input  logic               cfg_lson,
  input  logic               cfg_pss,
  input  logic [NIRQ-1:0]    irq_req,
  input  logic [NIRQ-1:0]    irq_en,
  input  logic               nmi,
  input  logic [NPI-1:0]     pirq_req,
  input  logic [NPI-1:0]     pirq_en,
  input  logic               cpu_mask,
  input  logic               res_n,
  input  logic               stby_n,
  input  logic [CNT_W-1:0]   stab_cycles,
  output logic               cpu_clk_en,
  output logic [NPER-1:0]    per_clk_en,
  output logic               exc_start,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [2:0]         mode
);
  pm_mode_e           mode_q, mode_nxt;
  logic               stab_load, stab_done;
  logic               wake_vld;
  logic [CAUSE_W-1:0] wake_cause;
  logic               pulse_nxt;
  logic [CAUSE_W-1:0] cause_nxt;
  logic               sub_ok, back_ok;

  assign sub_ok  = sleep_stb && !cfg_ssby && cfg_lson && cfg_pss;
  assign back_ok = sleep_stb && !cfg_ssby && !cfg_lson;

  pwr_wake_arb #(.NIRQ(NIRQ), .NPI(NPI)) u_arb (
    .nmi       (nmi),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .pirq_req  (pirq_req),
    .pirq_en   (pirq_en),
    .cpu_mask  (cpu_mask),
    .wake_vld  (wake_vld),
    .wake_cause(wake_cause)
  );

  pwr_stab_cnt #(.CNT_W(CNT_W)) u_stab (
    .clk     (clk),
    .rst     (rst),
    .load    (stab_load),
    .run     (mode_q == PM_RESET),
    .load_val(stab_cycles),
    .done    (stab_done)
  );

  pwr_clk_gate #(.NPER(NPER), .KEEP_MASK(KEEP_MASK)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .mode_nxt(mode_nxt),
    .cpu_en  (cpu_clk_en),
    .per_en  (per_clk_en)
  );

  // Pin overrides first, then per-mode sequencing.
  always_comb begin
    mode_nxt  = mode_q;
    stab_load = 1'b0;
    pulse_nxt = 1'b0;
    cause_nxt = exc_cause;
    if (!stby_n) begin
      mode_nxt = PM_HWSTBY;
    end else if (!res_n) begin
      mode_nxt  = PM_RESET;
      stab_load = (mode_q != PM_RESET);
    end else begin
      case (mode_q)
        PM_RESET: if (stab_done) begin
          mode_nxt  = PM_ACTIVE;
          pulse_nxt = 1'b1;
          cause_nxt = CZ_RESET;
        end
        PM_ACTIVE: if (sub_ok) mode_nxt = PM_SUBACT;
        PM_SUBACT: begin
          if (sub_ok)       mode_nxt = PM_SUBSLP;
          else if (back_ok) mode_nxt = PM_ACTIVE;
        end
        PM_SUBSLP: if (wake_vld) begin
          mode_nxt  = PM_SUBACT;
          pulse_nxt = 1'b1;
          cause_nxt = wake_cause;
        end
        default: mode_nxt = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PM_RESET;
      exc_start <= 1'b0;
      exc_cause <= CZ_NONE;
    end else begin
      mode_q    <= mode_nxt;
      exc_start <= pulse_nxt;
      exc_cause <= cause_nxt;
    end
  end

  assign mode = mode_q;

  assert_sleep_from_subact_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SUBSLP && $past(mode_q) != PM_SUBSLP) |-> $past(mode_q) == PM_SUBACT);

  assert_stby_forces_R4: assert property (@(posedge clk) disable iff (rst)
    !stby_n |=> mode_q == PM_HWSTBY);

  assert_hwstby_exit_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == PM_HWSTBY && mode_q != PM_HWSTBY) |-> mode_q == PM_RESET);

  assert_reset_wait_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == PM_RESET && mode_q == PM_ACTIVE) |->
      ($past(stab_done) && exc_start && exc_cause == CZ_RESET));

  assert_pulse_one_R12: assert property (@(posedge clk) disable iff (rst)
    exc_start |=> !exc_start);

  assert_sleep_gates_R7: assert property (@(posedge clk) disable iff (rst)
    mode_q == PM_SUBSLP |-> (!cpu_clk_en && per_clk_en == KEEP_MASK));

  assert_frozen_cause_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SUBSLP && $past(mode_q) == PM_SUBSLP) |-> $stable(exc_cause));

  assert_wake_to_subact_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_start && exc_cause != CZ_RESET) |-> (mode_q == PM_SUBACT && $past(mode_q) == PM_SUBSLP));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int NIRQ = 8;
  localparam int NPI  = 4;
  localparam int NPER = 8;
  localparam logic [NPER-1:0] KEEP = 8'h0F;
  localparam int CNT_W = 8;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst, sleep_stb, cfg_ssby, cfg_lson, cfg_pss, nmi, cpu_mask, res_n, stby_n;
  logic [NIRQ-1:0] irq_req, irq_en;
  logic [NPI-1:0]  pirq_req, pirq_en;
  logic [CNT_W-1:0] stab_cycles;
  logic cpu_clk_en, exc_start;
  logic [NPER-1:0] per_clk_en;
  logic [3:0] exc_cause;
  logic [2:0] mode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NIRQ(NIRQ), .NPI(NPI), .NPER(NPER), .KEEP_MASK(KEEP), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .cfg_ssby(cfg_ssby), .cfg_lson(cfg_lson),
    .cfg_pss(cfg_pss), .irq_req(irq_req), .irq_en(irq_en), .nmi(nmi), .pirq_req(pirq_req),
    .pirq_en(pirq_en), .cpu_mask(cpu_mask), .res_n(res_n), .stby_n(stby_n),
    .stab_cycles(stab_cycles), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .exc_start(exc_start), .exc_cause(exc_cause), .mode(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_sleep(input logic [2:0] c);
    {cfg_ssby, cfg_lson, cfg_pss} = c;
    sleep_stb = 1'b1;
    tick();
    sleep_stb = 1'b0;
  endtask

  task automatic wake_nmi();
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
  endtask

  task automatic measure_exit(input string req, input int exp);
    int n = 0;
    do begin
      tick();
      n++;
    end while (mode != 3'd2 && n < 400);
    check(req, n, exp);
    check(req, exc_start, 1);
    check(req, exc_cause, 1);
  endtask

  initial begin
    rst = 1'b1; sleep_stb = 1'b0; cfg_ssby = 1'b0; cfg_lson = 1'b0; cfg_pss = 1'b0;
    nmi = 1'b0; cpu_mask = 1'b0; res_n = 1'b1; stby_n = 1'b1;
    irq_req = '0; irq_en = '0; pirq_req = '0; pirq_en = '0; stab_cycles = CNT_W'(S);
    repeat (3) tick();
    check("R1 mode", mode, 1);
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 per_clk_en", per_clk_en, 8'hFF);
    check("R1 exc_start", exc_start, 0);
    check("R1 exc_cause", exc_cause, 0);
    rst = 1'b0;
    measure_exit("R3 exit after rst", S + 1);
    tick();
    check("R12 pulse width", exc_start, 0);
    check("R12 cause held", exc_cause, 1);

    // R5/R6: every strobe combination from active mode
    for (int c = 0; c < 8; c++) begin
      pulse_sleep(3'(c));
      if (c == 3) begin
        check("R5 active->subact", mode, 3);
        pulse_sleep(3'b000);
        check("R5 subact->active", mode, 2);
      end else begin
        check("R6 active ignores", mode, 2);
      end
    end

    // R6/R7/R8: every strobe combination from sub-active mode
    pulse_sleep(3'b011);
    for (int c = 0; c < 8; c++) begin
      int exp_m;
      exp_m = (c == 3) ? 4 : ((c >> 1) == 0) ? 2 : 3;
      pulse_sleep(3'(c));
      check("R6 subact strobe", mode, exp_m);
      if (exp_m == 4) begin
        check("R7 sleep cpu clk", cpu_clk_en, 0);
        check("R7 sleep per clk", per_clk_en, KEEP);
        wake_nmi();
        check("R8 nmi wake mode", mode, 3);
        check("R8 nmi pulse", exc_start, 1);
        check("R8 nmi cause", exc_cause, 2);
        check("R7 wake clocks", per_clk_en, 8'hFF);
      end else if (exp_m == 2) begin
        pulse_sleep(3'b011);
      end
    end

    // R9: each IRQ line, disabled then enabled
    for (int k = 0; k < NIRQ; k++) begin
      pulse_sleep(3'b011);
      irq_req = NIRQ'(1) << k;
      irq_en  = ~(NIRQ'(1) << k);
      for (int w = 0; w < 3; w++) begin
        tick();
        check("R9 disabled no wake", mode, 4);
        check("R9 disabled no pulse", exc_start, 0);
        check("R12 cause frozen", exc_cause, 2);
        check("R9 clocks frozen", cpu_clk_en, 0);
      end
      irq_en = '1;
      tick();
      check("R9 irq wake mode", mode, 3);
      check("R9 irq pulse", exc_start, 1);
      check("R9 irq cause", exc_cause, 4 + k);
      irq_req = '0; irq_en = '0;
      tick();
      pulse_sleep(3'b011);
      wake_nmi();
    end

    // R10: peripheral enable/mask combinations per line
    for (int p = 0; p < NPI; p++) begin
      for (int m = 0; m < 4; m++) begin
        pulse_sleep(3'b011);
        pirq_req = NPI'(1) << p;
        pirq_en  = (m % 2 == 1) ? (NPI'(1) << p) : ~(NPI'(1) << p);
        cpu_mask = (m >= 2);
        tick();
        if (m == 1) begin
          check("R10 periph wake mode", mode, 3);
          check("R10 periph cause", exc_cause, 12);
          check("R10 periph pulse", exc_start, 1);
        end else begin
          check("R10 blocked periph", mode, 4);
          check("R10 blocked pulse", exc_start, 0);
        end
        pirq_req = '0; pirq_en = '0; cpu_mask = 1'b0;
        if (m != 1) wake_nmi();
      end
    end

    // R11: priority between simultaneous sources
    pulse_sleep(3'b011);
    nmi = 1'b1; irq_req = 8'h08; irq_en = '1; pirq_req = '1; pirq_en = '1;
    tick();
    check("R11 nmi first", exc_cause, 2);
    nmi = 1'b0; irq_req = '0; pirq_req = '0;
    pulse_sleep(3'b011);
    irq_req = 8'h24;
    tick();
    check("R11 lowest irq", exc_cause, 6);
    irq_req = '0;
    pulse_sleep(3'b011);
    irq_req = 8'h80; pirq_req = 4'h2;
    tick();
    check("R11 irq over periph", exc_cause, 11);
    irq_req = '0; pirq_req = '0; irq_en = '0; pirq_en = '0;
    pulse_sleep(3'b011);
    nmi = 1'b1; res_n = 1'b0;
    tick();
    check("R11 reset over nmi", mode, 1);
    check("R11 no irq pulse", exc_start, 0);
    check("R2 clocks in reset", per_clk_en, 8'hFF);
    nmi = 1'b0; res_n = 1'b1;
    measure_exit("R3 early release", S + 1);

    // R8: interrupts outside sub-sleep are ignored
    tick();
    nmi = 1'b1; irq_req = '1; irq_en = '1;
    tick();
    check("R8 active ignores nmi", mode, 2);
    check("R8 active no pulse", exc_start, 0);
    nmi = 1'b0; irq_req = '0; irq_en = '0;

    // R4: standby from sub-sleep, with reset also low
    pulse_sleep(3'b011);
    pulse_sleep(3'b011);
    stby_n = 1'b0; res_n = 1'b0;
    tick();
    check("R4 standby mode", mode, 0);
    check("R4 standby cpu", cpu_clk_en, 0);
    check("R4 standby per", per_clk_en, 0);
    pulse_sleep(3'b011);
    check("R4 strobe ignored", mode, 0);
    res_n = 1'b1; stby_n = 1'b1;
    nmi = 1'b1;
    for (int w = 0; w < 3; w++) begin
      tick();
      check("R4 only reset leaves", mode, 0);
    end
    nmi = 1'b0;
    res_n = 1'b0;
    tick();
    check("R2 standby->reset", mode, 1);
    check("R7 reset clocks", cpu_clk_en, 1);
    repeat (S + 4) tick();
    check("R3 held while pin low", mode, 1);
    res_n = 1'b1;
    measure_exit("R3 late release", 1);

    // R4: standby from active mode
    stby_n = 1'b0;
    tick();
    check("R4 active->standby", mode, 0);
    stby_n = 1'b1;

    // R3: zero stabilization count
    stab_cycles = '0;
    res_n = 1'b0;
    tick();
    check("R2 entry", mode, 1);
    res_n = 1'b1;
    measure_exit("R3 zero count", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1..R12 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule